// File: doc/BRIEF.md
# Protected GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits behind a single-cycle register bus. Software owns an output latch, a per-pin direction mask and a synchronized view of the pin levels. Output bits can be loaded whole, or changed in place by writing a mask to a set, clear or toggle location. With these, two agents can touch different pins without a read-modify-write race.

Every bus access carries two attributes, privileged and secure. An attribute-check register maps them to one of three access classes and grants or refuses the read and the write. The same check guards the attribute register itself. A sticky lock bit freezes the chosen permission mode until reset. A refused access has no side effect, returns zero, and raises a one-cycle error pulse.

The bus has no back-pressure. An access is offered for exactly one cycle and is always complete at the next clock edge, so the block has no valid/ready pair. Read data and the error flag are registered and appear in the cycle after the access. In every cycle without a read, read data is zero.

Top module: `gpio_guard_port`

## Requirements
- R1: After reset, all registers are zero. `pin_oe`, `pin_out`, `bus_rdata` and `bus_err` are all zero.
- R2: The output latch lives at offset 0x00 and the direction mask at 0x14. Both are read-write. `pin_oe` equals the direction mask. `pin_out` bit n equals latch bit n while direction bit n is 1, and is 0 otherwise.
- R3: Writing a mask updates the output latch by offset:
  - 0x04 forces each masked bit to 1.
  - 0x08 forces each masked bit to 0.
  - 0x0C inverts each masked bit.
  - Zero bits in the mask leave the latch unchanged.
  - All three offsets read as zero.
- R4: Offset 0x10 is read-only and reads the pin levels after a two-flop synchronizer. Bits whose `pin_dig_en` is 0 read 0. Writes to 0x10 have no effect. A pin change made just before an edge is visible to a read issued two cycles later, and not to one issued one cycle later.
- R5: Read data is registered and appears the cycle after `bus_re`. A read of an unmapped offset returns zero. A read and a write in the same cycle to the same offset return the value from before the write.
- R6: The access class is chosen as follows:
  - privileged and secure: class PS.
  - secure but not privileged: class US.
  - any access that is not secure: class UN.

  Mode = bits [2:0] at 0x1C. In the grants below, "read" means read only and "none" means no access. Any class not listed for a mode keeps read and write.

  | Mode | Grants |
  |------|--------|
  | 0 | all classes keep read and write |
  | 1 | UN read |
  | 2 | UN none |
  | 3 | UN read, US read |
  | 4 | UN none, US read |
  | 5 | UN none, US none |
  | 6 | UN none, US none, PS read |
  | 7 | all classes none |

- R7: A refused write changes nothing. A refused read returns zero. Either kind of refusal sets `bus_err` for exactly the one cycle after the access.
- R8: Bit 7 at 0x1C is a lock:
  - Any granted write of a 1 to bit 7 sets it.
  - Once set, only reset clears it.
  - While it is set, writes to bits [2:0] are ignored.
  - A single write may set the mode and the lock together.
  - Bits [6:3] at 0x1C read as zero.
- R9: The mode check applies to offset 0x1C itself. A class without write permission cannot change the mode or the lock, and its attempt raises `bus_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_priv | input | 1 | Access is privileged |
| bus_secure | input | 1 | Access is secure |
| bus_rdata | output | 8 | Registered read data, zero when no read occurred |
| bus_err | output | 1 | One-cycle pulse after a refused access |
| pin_out | output | 8 | Output level per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_in | input | 8 | Raw pin level, asynchronous |
| pin_dig_en | input | 8 | Pin enabled for digital input |

## Verification
A read and a write can hit the same offset in one cycle. Permission is then judged separately for each, and the read must return the pre-write value. The bench provokes this by raising both strobes on the output latch, first under full access and then under a mode that grants the class read but not write. The scoreboard expects the old latch value with no error in the first case, and the old value with an error pulse and an unchanged latch in the second. A write to the attribute register that changes the mode and the lock together is also judged against the mode in force before the edge, and the bench checks this by reading the result back.

// File: rtl/gpio_guard_pkg.sv
package gpio_guard_pkg;

  localparam logic [7:0] OFS_DOUT = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_TGL  = 8'h0C;
  localparam logic [7:0] OFS_DIN  = 8'h10;
  localparam logic [7:0] OFS_DIR  = 8'h14;
  localparam logic [7:0] OFS_ATTR = 8'h1C;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    CLS_UN = 2'd0,
    CLS_US = 2'd1,
    CLS_PS = 2'd2
  } acc_class_e;

  typedef enum logic [1:0] {
    OUT_LOAD = 2'd0,
    OUT_SET  = 2'd1,
    OUT_CLR  = 2'd2,
    OUT_TGL  = 2'd3
  } out_op_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } grant_t;

  // Grant vector ordered {ps_rd, ps_wr, us_rd, us_wr, un_rd, un_wr}
  function automatic logic [5:0] mode_grants(input logic [MODE_W-1:0] mode);
    logic [5:0] g;
    case (mode)
      3'd0:    g = 6'b11_11_11;
      3'd1:    g = 6'b11_11_10;
      3'd2:    g = 6'b11_11_00;
      3'd3:    g = 6'b11_10_10;
      3'd4:    g = 6'b11_10_00;
      3'd5:    g = 6'b11_00_00;
      3'd6:    g = 6'b10_00_00;
      default: g = 6'b00_00_00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/gpio_guard_perm.sv
module gpio_guard_perm
  import gpio_guard_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              priv,
  input  logic              secure,
  output logic              rd_ok,
  output logic              wr_ok
);

  acc_class_e cls;
  logic [5:0] table_row;
  grant_t     pick;

  always_comb begin
    if (secure && priv)   cls = CLS_PS;
    else if (secure)      cls = CLS_US;
    else                  cls = CLS_UN;
  end

  always_comb begin
    table_row = mode_grants(mode);
    case (cls)
      CLS_PS:  pick = grant_t'(table_row[5:4]);
      CLS_US:  pick = grant_t'(table_row[3:2]);
      default: pick = grant_t'(table_row[1:0]);
    endcase
  end

  assign rd_ok = pick.rd;
  assign wr_ok = pick.wr;

endmodule

// File: rtl/gpio_guard_sync.sv
module gpio_guard_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_guard_outreg.sv
module gpio_guard_outreg
  import gpio_guard_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  out_op_e          op,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (op)
        OUT_SET: nxt[i] = q[i] | mask[i];
        OUT_CLR: nxt[i] = q[i] & ~mask[i];
        OUT_TGL: nxt[i] = q[i] ^ mask[i];
        default: nxt[i] = mask[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end

endmodule

// File: rtl/gpio_guard_port.sv
module gpio_guard_port
  import gpio_guard_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_priv,
  input  logic              bus_secure,
  output logic [PINS-1:0]   bus_rdata,
  output logic              bus_err,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   pin_dig_en
);

  localparam int LOCK_BIT = PINS - 1;
  localparam int PAD_W    = PINS - MODE_W - 1;

  logic [MODE_W-1:0] mode_q;
  logic              lock_q;
  logic [PINS-1:0]   dir_q;
  logic [PINS-1:0]   dout_q;
  logic [PINS-1:0]   pin_sync;
  logic [PINS-1:0]   din_view;
  logic              rd_ok, wr_ok;
  logic              rd_go, wr_go;
  logic              hit_dout, hit_set, hit_clr, hit_tgl;
  logic              hit_din, hit_dir, hit_attr;
  logic              out_upd;
  out_op_e           out_op;
  logic [PINS-1:0]   rd_val;
  logic [PINS-1:0]   rdata_q;
  logic              err_q;

  // Access class and mode check
  gpio_guard_perm u_perm (
    .mode   (mode_q),
    .priv   (bus_priv),
    .secure (bus_secure),
    .rd_ok  (rd_ok),
    .wr_ok  (wr_ok)
  );

  assign rd_go = bus_re & rd_ok;
  assign wr_go = bus_we & wr_ok;

  // Offset decode
  assign hit_dout = (bus_addr == ADDR_W'(OFS_DOUT));
  assign hit_set  = (bus_addr == ADDR_W'(OFS_SET));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));
  assign hit_tgl  = (bus_addr == ADDR_W'(OFS_TGL));
  assign hit_din  = (bus_addr == ADDR_W'(OFS_DIN));
  assign hit_dir  = (bus_addr == ADDR_W'(OFS_DIR));
  assign hit_attr = (bus_addr == ADDR_W'(OFS_ATTR));

  // Output latch and its atomic update paths
  assign out_upd = wr_go & (hit_dout | hit_set | hit_clr | hit_tgl);

  always_comb begin
    if (hit_set)      out_op = OUT_SET;
    else if (hit_clr) out_op = OUT_CLR;
    else if (hit_tgl) out_op = OUT_TGL;
    else              out_op = OUT_LOAD;
  end

  gpio_guard_outreg #(.WIDTH(PINS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (out_upd),
    .op    (out_op),
    .mask  (bus_wdata),
    .q     (dout_q)
  );

  // Direction mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dir_q <= '0;
    else if (wr_go & hit_dir) dir_q <= bus_wdata;
  end

  // Attribute check register: mode frozen by a sticky lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_go & hit_attr) begin
      if (!lock_q)               mode_q <= bus_wdata[MODE_W-1:0];
      if (bus_wdata[LOCK_BIT])   lock_q <= 1'b1;
    end
  end

  // Pin input path
  gpio_guard_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  assign din_view = pin_sync & pin_dig_en;

  // Read mux
  always_comb begin
    rd_val = '0;
    if (hit_dout)      rd_val = dout_q;
    else if (hit_din)  rd_val = din_view;
    else if (hit_dir)  rd_val = dir_q;
    else if (hit_attr) rd_val = {lock_q, {PAD_W{1'b0}}, mode_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_go ? rd_val : '0;
      err_q   <= (bus_re & ~rd_ok) | (bus_we & ~wr_ok);
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign pin_oe    = dir_q;
  assign pin_out   = dout_q & dir_q;

endmodule

// File: rtl/gpio_guard_chk.sv
module gpio_guard_chk
  import gpio_guard_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [PINS-1:0]   bus_rdata,
  input logic              bus_err,
  input logic [MODE_W-1:0] mode_q,
  input logic              lock_q,
  input logic [PINS-1:0]   dout_q
);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mode_q));

  a_r3_set_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_SET))
      |=> (bus_err || ((dout_q & $past(bus_wdata)) == $past(bus_wdata))));

  a_r3_clr_forces_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_CLR))
      |=> (bus_err || ((dout_q & $past(bus_wdata)) == '0)));

  a_r7_blocked_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_re) |=> (!bus_err || $stable(dout_q)));

  a_r7_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we) |=> (!bus_err || bus_rdata == '0));

  a_r7_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_re && !bus_we) |=> !bus_err);

  a_r6_mode7_refuses_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd7 && (bus_re || bus_we)) |=> bus_err);

endmodule

bind gpio_guard_port gpio_guard_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .mode_q    (mode_q),
  .lock_q    (lock_q),
  .dout_q    (dout_q)
);

// File: tb/tb_gpio_guard_port.sv
`timescale 1ns/1ps
module tb_gpio_guard_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b0, bus_secure = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_err;
  logic [7:0] pin_out, pin_oe;
  logic [7:0] pin_in = '0, pin_dig_en = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] q_rd  [$];
  logic       q_err [$];
  string      q_tag [$];

  always #4 clk = ~clk;

  gpio_guard_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_in(pin_in), .pin_dig_en(pin_dig_en)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Driver: offers one access for one cycle and queues the expected result
  task automatic acc(input logic we, input logic re, input logic [4:0] a,
                     input logic [7:0] d, input logic pv, input logic sc,
                     input logic [7:0] exp_rd, input logic exp_err, input string req);
    q_rd.push_back(exp_rd);
    q_err.push_back(exp_err);
    q_tag.push_back(req);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    bus_priv = pv; bus_secure = sc;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  // Class shorthands: PS = 2'b11, US = 2'b01, UN = 2'b00, privileged non-secure = 2'b10
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [1:0] c,
                    input logic exp_err, input string req);
    acc(1'b1, 1'b0, a, d, c[1], c[0], 8'h00, exp_err, req);
  endtask

  task automatic rd(input logic [4:0] a, input logic [1:0] c, input logic [7:0] exp,
                    input logic exp_err, input string req);
    acc(1'b0, 1'b1, a, 8'h00, c[1], c[0], exp, exp_err, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_we = 1'b0; bus_re = 1'b0;
    repeat (2) @(negedge clk);
    chk8("R1 oe in reset", pin_oe, 8'h00);
    chk8("R1 out in reset", pin_out, 8'h00);
    chk8("R1 rdata in reset", bus_rdata, 8'h00);
    chk8("R1 err in reset", {7'd0, bus_err}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per access edge
  initial begin
    forever begin
      logic act;
      @(posedge clk);
      act = rst_n && (bus_we || bus_re);
      #1;
      if (act) begin
        if (q_rd.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: actual access expected none");
        end else begin
          logic [7:0] e_rd;
          logic       e_err;
          string      tag;
          e_rd = q_rd.pop_front();
          e_err = q_err.pop_front();
          tag = q_tag.pop_front();
          chk8({tag, " rdata"}, bus_rdata, e_rd);
          chk8({tag, " err"}, {7'd0, bus_err}, {7'd0, e_err});
        end
      end
    end
  end

  localparam logic [1:0] PS = 2'b11, US = 2'b01, UN = 2'b00, PN = 2'b10;

  initial begin
    do_reset();
    rd(5'h00, PS, 8'h00, 0, "R1 dout");
    rd(5'h14, PS, 8'h00, 0, "R1 dir");
    rd(5'h1C, PS, 8'h00, 0, "R1 attr");
    rd(5'h10, PS, 8'h00, 0, "R1 din");

    // R2
    wr(5'h14, 8'hF0, PS, 0, "R2 dir wr");
    wr(5'h00, 8'hA5, PS, 0, "R2 dout wr");
    chk8("R2 pin_oe", pin_oe, 8'hF0);
    chk8("R2 pin_out", pin_out, 8'hA0);
    rd(5'h00, PS, 8'hA5, 0, "R2 dout rd");

    // R3
    wr(5'h04, 8'h0A, PS, 0, "R3 set");
    rd(5'h00, PS, 8'hAF, 0, "R3 after set");
    wr(5'h08, 8'h81, PS, 0, "R3 clr");
    rd(5'h00, PS, 8'h2E, 0, "R3 after clr");
    wr(5'h0C, 8'hFF, PS, 0, "R3 tgl");
    rd(5'h00, PS, 8'hD1, 0, "R3 after tgl");
    chk8("R3 pin_out", pin_out, 8'hD0);
    wr(5'h04, 8'h00, PS, 0, "R3 zero mask");
    wr(5'h08, 8'h00, PS, 0, "R3 zero mask");
    rd(5'h04, PS, 8'h00, 0, "R3 set reads 0");
    rd(5'h08, PS, 8'h00, 0, "R3 clr reads 0");
    rd(5'h0C, PS, 8'h00, 0, "R3 tgl reads 0");
    rd(5'h00, PS, 8'hD1, 0, "R3 unchanged");

    // R4
    pin_dig_en = 8'h0F; pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(5'h10, PS, 8'h0C, 0, "R4 masked din");
    wr(5'h10, 8'hFF, PS, 0, "R4 write din");
    rd(5'h10, PS, 8'h0C, 0, "R4 din unchanged");
    pin_dig_en = 8'hFF;
    pin_in = 8'hC3;
    rd(5'h10, PS, 8'h3C, 0, "R4 sync lat 0");
    rd(5'h10, PS, 8'h3C, 0, "R4 sync lat 1");
    rd(5'h10, PS, 8'hC3, 0, "R4 sync lat 2");

    // R5
    rd(5'h18, PS, 8'h00, 0, "R5 unmapped 18");
    rd(5'h01, PS, 8'h00, 0, "R5 unmapped 01");
    acc(1'b1, 1'b1, 5'h00, 8'h55, 1'b1, 1'b1, 8'hD1, 0, "R5 rd+wr old");
    rd(5'h00, PS, 8'h55, 0, "R5 after rd+wr");

    // R6 / R7 / R9 across modes
    wr(5'h1C, 8'h01, PS, 0, "R6 mode1");
    wr(5'h00, 8'hFF, UN, 1, "R6 mode1 UN wr");
    rd(5'h00, UN, 8'h55, 0, "R6 mode1 UN rd");
    wr(5'h00, 8'hFF, PN, 1, "R6 priv nonsec as UN");
    acc(1'b1, 1'b1, 5'h00, 8'h99, 1'b0, 1'b0, 8'h55, 1, "R5 rd+wr split grant");
    rd(5'h00, PS, 8'h55, 0, "R7 split write dropped");
    wr(5'h00, 8'h66, US, 0, "R6 mode1 US wr");
    rd(5'h00, US, 8'h66, 0, "R6 mode1 US rd");

    wr(5'h1C, 8'h03, PS, 0, "R6 mode3");
    wr(5'h00, 8'h00, US, 1, "R6 mode3 US wr");
    rd(5'h00, US, 8'h66, 0, "R6 mode3 US rd");
    rd(5'h00, UN, 8'h66, 0, "R6 mode3 UN rd");

    wr(5'h1C, 8'h02, PS, 0, "R6 mode2");
    rd(5'h00, UN, 8'h00, 1, "R7 blocked rd zero");
    wr(5'h00, 8'h77, US, 0, "R6 mode2 US wr");
    wr(5'h1C, 8'h00, UN, 1, "R9 UN attr wr");
    rd(5'h1C, PS, 8'h02, 0, "R9 mode kept");

    wr(5'h1C, 8'h04, PS, 0, "R6 mode4");
    rd(5'h00, UN, 8'h00, 1, "R6 mode4 UN rd");
    rd(5'h00, US, 8'h77, 0, "R6 mode4 US rd");
    wr(5'h00, 8'h00, US, 1, "R6 mode4 US wr");

    wr(5'h1C, 8'h05, PS, 0, "R6 mode5");
    rd(5'h00, US, 8'h00, 1, "R6 mode5 US rd");
    wr(5'h00, 8'h11, PS, 0, "R6 mode5 PS wr");
    wr(5'h04, 8'hFF, US, 1, "R7 blocked set");
    rd(5'h00, PS, 8'h11, 0, "R7 no side effect");

    // R8
    wr(5'h1C, 8'hFD, PS, 0, "R8 lock+mode");
    rd(5'h1C, PS, 8'h85, 0, "R8 attr readback");
    wr(5'h1C, 8'h00, PS, 0, "R8 locked wr");
    rd(5'h1C, PS, 8'h85, 0, "R8 still locked");
    do_reset();
    rd(5'h1C, PS, 8'h00, 0, "R8 reset clears lock");

    wr(5'h1C, 8'h06, PS, 0, "R6 mode6");
    rd(5'h00, PS, 8'h00, 0, "R6 mode6 PS rd");
    wr(5'h00, 8'hFF, PS, 1, "R6 mode6 PS wr");
    wr(5'h1C, 8'h00, PS, 1, "R9 mode6 attr wr");
    rd(5'h1C, PS, 8'h06, 0, "R9 mode6 kept");
    do_reset();

    wr(5'h1C, 8'h07, PS, 0, "R6 mode7");
    rd(5'h00, PS, 8'h00, 1, "R6 mode7 PS rd");
    wr(5'h1C, 8'h80, PS, 1, "R9 mode7 attr wr");
    do_reset();
    rd(5'h1C, PS, 8'h00, 0, "R1 clean after reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule